// File: doc/BRIEF.md
# Supply Fault Reset Sequencer

This block turns two digitized supply comparator flags, one for over-voltage and one for under-voltage, into the system reset. A flag must stay active for a full debounce interval before it counts. A short glitch is filtered out. Once a fault qualifies, reset is asserted and held for as long as the fault lasts. When the fault clears, a release delay starts. Reset drops only when that delay completes without interruption. A qualified fault that arrives while the delay is running holds reset again and then starts a completely fresh delay. The total reset time can therefore exceed one nominal delay.

Both the debounce length and the delay length are counted in ticks of an external time base, which is a one-clock strobe. The block drives an active-high reset and an active-low reset that are exact complements. It also drives a watchdog clear level that holds a downstream window watchdog in its initial state for the whole reset interval. After reset that watchdog must see three good triggers before it enables anything. On power-up the block starts with reset asserted and runs one full delay before the first release. Both comparator flags pass through a two-flop synchronizer before they are evaluated.

Top module: `supply_reset_seq`

## Requirements
- R1: A pulse on either flag that lasts fewer than DEB_TICKS time-base ticks after synchronization produces no change on any output. This holds both while the block is released and while a release delay is running.
- R2: A fault that stays active for DEB_TICKS ticks asserts reset, and reset stays asserted for as long as the fault remains active.
- R3: After a qualified fault clears, reset stays asserted for DLY_TICKS further ticks and is then released.
- R4: A qualified fault during a running release delay cancels that delay. A fresh full delay of DLY_TICKS ticks then starts from the moment the new fault clears.
- R5: The debounce count restarts from zero whenever the flag goes inactive before the count expires, so two separate short pulses never add up to a qualified fault.
- R6: `sys_rst_o` is 1 during reset and 0 otherwise, and `sys_rst_no` is always its complement.
- R7: `wd_clr_o` is 1 for the whole reset interval and 0 once reset is released, so the watchdog restarts from its initial state.
- R8: While `por_ni` is low the outputs show reset (`sys_rst_o`=1, `sys_rst_no`=0, `wd_clr_o`=1). After `por_ni` rises, one full delay of DLY_TICKS ticks runs before reset is released.
- R9: The over-voltage flag and the under-voltage flag use the same synchronizer, debounce path and delay, with identical timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| por_ni | input | 1 | Raw power-up indication, active low, asynchronous assert |
| tick_i | input | 1 | Time-base strobe, one clock wide, that paces debounce and delay |
| ovf_i | input | 1 | Over-voltage comparator flag, asynchronous, 1 = fault |
| uvf_i | input | 1 | Under-voltage comparator flag, asynchronous, 1 = fault |
| sys_rst_o | output | 1 | System reset, active high |
| sys_rst_no | output | 1 | System reset, active low |
| wd_clr_o | output | 1 | Holds the watchdog in its initial state while 1 |

## Verification
The bench targets three kinds of mistake.

The first is a debounce that is too short or that accumulates. Glitches just under the debounce length, including two of them separated by a small gap, must leave reset untouched. A design that forgets to restart its count would raise reset on the second glitch.

The second is a delay that does not retrigger. A design that keeps counting its first delay during a second qualified fault would release reset too early, inside the window the second fault should have extended. A design that lets a sub-debounce glitch restart the delay would release too late.

The third is timing. Every reset edge is matched against a window of cycles derived from the tick count, and the complementary output and watchdog clear are checked at each edge, so a wrong delay or debounce length, a stuck output or an early power-up release is caught.

// File: rtl/srs_pkg.sv
package srs_pkg;

    typedef enum logic [1:0] {
        SEQ_HOLD  = 2'd0,
        SEQ_DELAY = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_e;

endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         por_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk_i or negedge por_ni) begin
            if (!por_ni) chain_q <= '0;
            else         chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/srs_debounce.sv
module srs_debounce #(
    parameter int DEB_TICKS = 4
) (
    input  logic clk_i,
    input  logic por_ni,
    input  logic tick_i,
    input  logic fault_i,
    output logic qual_o
);

    localparam int CW = (DEB_TICKS > 1) ? $clog2(DEB_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          qual;
    } deb_t;

    deb_t deb_d, deb_q;

    always_comb begin
        deb_d = deb_q;
        if (!fault_i) begin
            deb_d.cnt  = '0;
            deb_d.qual = 1'b0;
        end else if (!deb_q.qual && tick_i) begin
            if (deb_q.cnt == LAST) begin
                deb_d.qual = 1'b1;
                deb_d.cnt  = '0;
            end else begin
                deb_d.cnt = deb_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) deb_q <= '0;
        else         deb_q <= deb_d;
    end

    assign qual_o = deb_q.qual;

endmodule

// File: rtl/srs_seq.sv
module srs_seq
    import srs_pkg::*;
#(
    parameter int DLY_TICKS = 8
) (
    input  logic clk_i,
    input  logic por_ni,
    input  logic tick_i,
    input  logic qual_i,
    output logic rst_o,
    output logic wdc_o
);

    localparam int CW = (DLY_TICKS > 1) ? $clog2(DLY_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(DLY_TICKS - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic          rst;
        logic          wdc;
    } seq_t;

    localparam seq_t SEQ_INIT = '{state: SEQ_DELAY, cnt: '0, rst: 1'b1, wdc: 1'b1};

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            SEQ_HOLD: begin
                if (!qual_i) begin
                    seq_d.state = SEQ_DELAY;
                    seq_d.cnt   = '0;
                end
            end
            SEQ_DELAY: begin
                if (qual_i) begin
                    seq_d.state = SEQ_HOLD;
                    seq_d.cnt   = '0;
                end else if (tick_i) begin
                    if (seq_q.cnt == LAST) begin
                        seq_d.state = SEQ_RUN;
                        seq_d.cnt   = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            SEQ_RUN: begin
                if (qual_i) seq_d.state = SEQ_HOLD;
            end
            default: seq_d = SEQ_INIT;
        endcase
        seq_d.rst = (seq_d.state != SEQ_RUN);
        seq_d.wdc = (seq_d.state != SEQ_RUN);
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) seq_q <= SEQ_INIT;
        else         seq_q <= seq_d;
    end

    assign rst_o = seq_q.rst;
    assign wdc_o = seq_q.wdc;

endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq #(
    parameter int DEB_TICKS = 4,
    parameter int DLY_TICKS = 8
) (
    input  logic clk_i,
    input  logic por_ni,
    input  logic tick_i,
    input  logic ovf_i,
    input  logic uvf_i,
    output logic sys_rst_o,
    output logic sys_rst_no,
    output logic wd_clr_o
);

    localparam int NFLAG = 2;

    logic [NFLAG-1:0] flags_s;
    logic             fault_s;
    logic             qual;
    logic             rst_int;

    srs_sync #(.W(NFLAG), .STAGES(2)) sync_i (
        .clk_i   (clk_i),
        .por_ni  (por_ni),
        .async_i ({uvf_i, ovf_i}),
        .sync_o  (flags_s)
    );

    assign fault_s = |flags_s;

    srs_debounce #(.DEB_TICKS(DEB_TICKS)) deb_i (
        .clk_i   (clk_i),
        .por_ni  (por_ni),
        .tick_i  (tick_i),
        .fault_i (fault_s),
        .qual_o  (qual)
    );

    srs_seq #(.DLY_TICKS(DLY_TICKS)) seq_i (
        .clk_i  (clk_i),
        .por_ni (por_ni),
        .tick_i (tick_i),
        .qual_i (qual),
        .rst_o  (rst_int),
        .wdc_o  (wd_clr_o)
    );

    assign sys_rst_o  = rst_int;
    assign sys_rst_no = ~rst_int;

endmodule

// File: rtl/supply_reset_seq_chk.sv
module supply_reset_seq_chk (
    input logic clk_i,
    input logic por_ni,
    input logic fault_s,
    input logic qual,
    input logic sys_rst_o,
    input logic wd_clr_o
);

    // R1
    qual_needs_fault_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        $rose(qual) |-> $past(fault_s));

    // R2
    qual_forces_rst_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        qual |=> sys_rst_o);

    // R2
    rise_needs_qual_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        $rose(sys_rst_o) |-> $past(qual));

    // R3
    release_needs_clear_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        $fell(sys_rst_o) |-> !$past(qual));

    // R7
    wd_clr_cover_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        sys_rst_o |-> wd_clr_o);

endmodule

bind supply_reset_seq supply_reset_seq_chk chk_i (
    .clk_i     (clk_i),
    .por_ni    (por_ni),
    .fault_s   (fault_s),
    .qual      (qual),
    .sys_rst_o (sys_rst_o),
    .wd_clr_o  (wd_clr_o)
);

// File: tb/supply_reset_seq_tb_top.sv
`timescale 1ns/1ps
module supply_reset_seq_tb_top;

    localparam int TK  = 4;
    localparam int DEB = 4;
    localparam int DLY = 8;
    localparam int GLITCH = (DEB - 1) * TK - 2;

    typedef struct {
        bit    level;
        int    lo;
        int    hi;
        string tag;
    } edge_t;

    logic clk = 1'b0;
    logic por_ni = 1'b0;
    logic tick = 1'b0;
    logic ovf = 1'b0;
    logic uvf = 1'b0;
    logic sys_rst, sys_rst_n, wd_clr;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;
    bit   prev_rst = 1'b1;
    edge_t exp_q[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) tick <= ((cyc % TK) == 0);

    supply_reset_seq #(.DEB_TICKS(DEB), .DLY_TICKS(DLY)) dut_i (
        .clk_i      (clk),
        .por_ni     (por_ni),
        .tick_i     (tick),
        .ovf_i      (ovf),
        .uvf_i      (uvf),
        .sys_rst_o  (sys_rst),
        .sys_rst_no (sys_rst_n),
        .wd_clr_o   (wd_clr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push(input bit level, input int lo, input int hi, input string tag);
        edge_t e;
        e.level = level;
        e.lo    = lo;
        e.hi    = hi;
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // sel 0 = over-voltage, 1 = under-voltage; returns cycle of assertion
    task automatic set_flag(input bit sel, input bit val, output int t);
        @(negedge clk);
        if (sel) uvf = val;
        else     ovf = val;
        t = cyc;
    endtask

    task automatic glitch(input bit sel, input int len);
        int t;
        set_flag(sel, 1'b1, t);
        wait_cyc(len);
        if (sel) uvf = 1'b0;
        else     ovf = 1'b0;
    endtask

    // Monitor: every reset edge is popped and compared with its window.
    always @(negedge clk) begin
        if (por_ni && !done && (sys_rst !== prev_rst)) begin
            prev_rst = sys_rst;
            if (exp_q.size() == 0) begin
                chk(1'b0, "unexpected reset edge", int'(sys_rst), int'(!sys_rst));
            end else begin
                edge_t e;
                e = exp_q.pop_front();
                chk(sys_rst == e.level, e.tag, int'(sys_rst), int'(e.level));
                chk(cyc >= e.lo && cyc <= e.hi, {e.tag, " edge cycle"}, cyc, e.lo);
                // R6 complementary outputs at every edge
                chk(sys_rst_n == !sys_rst, "R6 complement", int'(sys_rst_n), int'(!sys_rst));
                // R7 watchdog clear tracks the reset interval
                chk(wd_clr == sys_rst, "R7 watchdog clear", int'(wd_clr), int'(sys_rst));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog timeout", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int t, t2, t3;
        wait_cyc(5);
        // R8 reset state while power-up indication is low
        chk(sys_rst == 1'b1, "R8 reset state sys_rst", int'(sys_rst), 1);
        chk(sys_rst_n == 1'b0, "R6 reset state sys_rst_n", int'(sys_rst_n), 0);
        chk(wd_clr == 1'b1, "R7 reset state wd_clr", int'(wd_clr), 1);
        @(negedge clk);
        t = cyc;
        push(1'b0, t + (DLY - 1) * TK - 2, t + DLY * TK + 8, "R8 power-up release");
        por_ni = 1'b1;
        wait_cyc(DLY * TK + 20);
        chk(sys_rst == 1'b0, "R8 released after power-up", int'(sys_rst), 0);

        // R1 short glitches on each flag do nothing
        glitch(1'b0, GLITCH);
        wait_cyc(40);
        chk(sys_rst == 1'b0, "R1 over-voltage glitch ignored", int'(sys_rst), 0);
        glitch(1'b1, GLITCH);
        wait_cyc(40);
        chk(sys_rst == 1'b0, "R1 under-voltage glitch ignored", int'(sys_rst), 0);

        // R5 two short pulses with a gap do not accumulate
        glitch(1'b0, GLITCH);
        wait_cyc(3);
        glitch(1'b0, GLITCH);
        wait_cyc(40);
        chk(sys_rst == 1'b0, "R5 debounce restart", int'(sys_rst), 0);

        // R2 / R3 long over-voltage fault
        set_flag(1'b0, 1'b1, t);
        push(1'b1, t + (DEB - 1) * TK, t + DEB * TK + 8, "R2 over-voltage assert");
        wait_cyc(DLY * TK * 2);
        chk(sys_rst == 1'b1, "R2 held during long fault", int'(sys_rst), 1);
        set_flag(1'b0, 1'b0, t2);
        push(1'b0, t2 + (DLY - 1) * TK, t2 + DLY * TK + 8, "R3 release delay");
        wait_cyc(DLY * TK + 20);

        // R9 under-voltage takes the same path
        set_flag(1'b1, 1'b1, t);
        push(1'b1, t + (DEB - 1) * TK, t + DEB * TK + 8, "R9 under-voltage assert");
        wait_cyc(30);
        set_flag(1'b1, 1'b0, t2);
        push(1'b0, t2 + (DLY - 1) * TK, t2 + DLY * TK + 8, "R9 under-voltage release");
        wait_cyc(DLY * TK + 20);

        // R4 qualified fault during the delay restarts a fresh delay
        set_flag(1'b0, 1'b1, t);
        push(1'b1, t + (DEB - 1) * TK, t + DEB * TK + 8, "R4 first fault assert");
        wait_cyc(30);
        set_flag(1'b0, 1'b0, t2);
        wait_cyc(12);
        set_flag(1'b1, 1'b1, t);
        wait_cyc(30);
        chk(sys_rst == 1'b1, "R4 first delay not completed", int'(sys_rst), 1);
        set_flag(1'b1, 1'b0, t3);
        push(1'b0, t3 + (DLY - 1) * TK, t3 + DLY * TK + 8, "R4 fresh delay release");
        wait_cyc(DLY * TK + 20);

        // R1 short glitch during a delay neither extends nor restarts it
        set_flag(1'b0, 1'b1, t);
        push(1'b1, t + (DEB - 1) * TK, t + DEB * TK + 8, "R1 setup assert");
        wait_cyc(30);
        set_flag(1'b0, 1'b0, t2);
        push(1'b0, t2 + (DLY - 1) * TK, t2 + DLY * TK + 8, "R1 glitch inside delay");
        wait_cyc(8);
        glitch(1'b1, GLITCH);
        wait_cyc(DLY * TK + 20);
        chk(sys_rst == 1'b0, "R1 released after delay glitch", int'(sys_rst), 0);

        chk(exp_q.size() == 0, "R3 all expected edges seen", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule